// File: doc/BRIEF.md
# Trailing-Bit Manipulation ALU

This unit evaluates one of a set of 32-bit bit-manipulation operations on a single source operand in one cycle. It returns the result, the same result zero-extended to 64 bits for a destination write, and a status-flag vector. The nine trailing-bit operations each combine the source with its increment or its decrement. Both of these come from one shared adder. The tenth operation is a bit-field extract whose start position and length are packed into a 16-bit control word.

All outputs come from one register stage behind a synchronous active-high reset. Inputs presented before a rising edge appear at the outputs just after that edge. Select codes that name no operation give a zero result, clear every flag and raise an illegal-operation indication.

Top module: `tbm_alu`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Results and flags appear one clock after the inputs are sampled, and `result_zx` always equals `result` with its upper 32 bits zero.
- R3: Select 0 is the field extract: start = `ctrl[7:0]`, length = `ctrl[15:8]`. The result is zero when start is 32 or more, or when length is 0. Otherwise it is `src >> start` masked to the low `length` bits, where a length of 32 or more keeps every bit shifted down.
- R4: Selects 1 to 6 use i = src+1 and give, in order: i&src, ~i|src, i&~src, i^src, i|src, i|~src.
- R5: Selects 7 to 9 use d = src-1 and give, in order: d|src, d|~src, d&~src.
- R6: For legal selects, `flag_zf` is 1 when the result is zero, `flag_sf` equals result bit 31, and `flag_pf` is 1 when result bits [7:0] hold an even number of ones.
- R7: `flag_of` and `flag_af` are always 0.
- R8: For selects 1 to 6, `flag_cf` is 1 exactly when `src` is all ones.
- R9: For selects 7 to 9, `flag_cf` is 1 exactly when `src` is zero.
- R10: For select 0, `flag_cf` is 0.
- R11: Selects 10 to 15 give a zero result with every flag 0 and `illegal_op` = 1. Every legal select gives `illegal_op` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Operation select |
| src | input | 32 | Source operand |
| ctrl | input | 16 | Extract control: start [7:0], length [15:8] |
| result | output | 32 | Registered result |
| result_zx | output | 64 | Result zero-extended to 64 bits |
| flag_zf | output | 1 | Zero flag |
| flag_sf | output | 1 | Sign flag |
| flag_pf | output | 1 | Parity flag (even parity of low byte) |
| flag_of | output | 1 | Overflow flag |
| flag_cf | output | 1 | Carry flag |
| flag_af | output | 1 | Auxiliary-carry flag |
| illegal_op | output | 1 | Select code names no operation |

## Verification
The assertions check, on every cycle, the relations that hold whatever the data is:
- the zero upper half of `result_zx`;
- the overflow and auxiliary-carry flags held at 0;
- zero and sign agreeing with the result;
- the carry rule for each operation group;
- the all-zero response to an undefined select.

Only the bench's scenarios can show that each result formula is correct. These scenarios are all-zero, all-ones, single-bit, alternating and random operands. For the extract they include start and length edge cases: start past bit 31, a field that runs off the top, and zero or oversized lengths. The same scenarios cover parity over the low byte and the behaviour of reset in the middle of a run.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  localparam int OPW = 4;
  // select codes; the grouping (increment ops, then decrement ops) drives carry logic
  localparam logic [OPW-1:0] OP_XTR       = 4'd0;
  localparam logic [OPW-1:0] OP_INC_FIRST = 4'd1;
  localparam logic [OPW-1:0] OP_INC_LAST  = 4'd6;
  localparam logic [OPW-1:0] OP_DEC_FIRST = 4'd7;
  localparam logic [OPW-1:0] OP_DEC_LAST  = 4'd9;

  typedef struct packed {
    logic zf;
    logic sf;
    logic pf;
    logic of;
    logic cf;
    logic af;
  } tbm_flags_t;
endpackage

// File: rtl/tbm_extract.sv
module tbm_extract #(
  parameter int W  = 32,
  parameter int FW = 8
) (
  input  logic [W-1:0]  x,
  input  logic [FW-1:0] start,
  input  logic [FW-1:0] len,
  output logic [W-1:0]  y
);
  logic [W-1:0] shifted;
  logic [W-1:0] keep;
  logic [W-1:0] ones;

  always_comb begin
    ones = '1;
    if (int'(start) >= W) shifted = '0;
    else                  shifted = x >> start;
    if (int'(len) >= W)   keep = '1;
    else                  keep = ~(ones << len);
    y = shifted & keep;
  end
endmodule

// File: rtl/tbm_trail.sv
module tbm_trail
  import tbm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   x,
  output logic [W-1:0]   y,
  output logic           cf
);
  logic         use_dec;
  logic [W-1:0] step_add;
  logic [W-1:0] step;
  logic         co;

  // one adder: +1 for increment ops, +all-ones (i.e. -1) for decrement ops
  always_comb begin
    use_dec  = (op >= OP_DEC_FIRST);
    step_add = use_dec ? {W{1'b1}} : {{(W-1){1'b0}}, 1'b1};
    {co, step} = {1'b0, x} + {1'b0, step_add};
  end

  always_comb begin
    case (op)
      4'd1:    y = step & x;
      4'd2:    y = ~step | x;
      4'd3:    y = step & ~x;
      4'd4:    y = step ^ x;
      4'd5:    y = step | x;
      4'd6:    y = step | ~x;
      4'd7:    y = step | x;
      4'd8:    y = step | ~x;
      4'd9:    y = step & ~x;
      default: y = '0;
    endcase
    // increment wraps (carry out) only for all-ones; decrement borrows only for zero
    cf = use_dec ? ~co : co;
  end
endmodule

// File: rtl/tbm_flags.sv
module tbm_flags
  import tbm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] y,
  input  logic         cf_in,
  input  logic         legal,
  output tbm_flags_t   f
);
  always_comb begin
    f = '0;
    if (legal) begin
      f.zf = ~|y;
      f.sf = y[W-1];
      f.pf = ~^y[7:0];
      f.cf = cf_in;
    end
  end
endmodule

// File: rtl/tbm_alu.sv
module tbm_alu
  import tbm_pkg::*;
#(
  parameter int W    = 32,
  parameter int CW   = 16,
  parameter int PIPE = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  op_sel,
  input  logic [W-1:0]    src,
  input  logic [CW-1:0]   ctrl,
  output logic [W-1:0]    result,
  output logic [2*W-1:0]  result_zx,
  output logic            flag_zf,
  output logic            flag_sf,
  output logic            flag_pf,
  output logic            flag_of,
  output logic            flag_cf,
  output logic            flag_af,
  output logic            illegal_op
);
  localparam int FW = CW / 2;

  logic [W-1:0] xtr_y, trl_y, sel_y;
  logic         trl_cf, sel_cf, legal;
  tbm_flags_t   fl_d;

  tbm_extract #(.W(W), .FW(FW)) u_xtr (
    .x(src), .start(ctrl[FW-1:0]), .len(ctrl[CW-1:FW]), .y(xtr_y)
  );

  tbm_trail #(.W(W)) u_trl (
    .op(op_sel), .x(src), .y(trl_y), .cf(trl_cf)
  );

  always_comb begin
    legal  = (op_sel <= OP_DEC_LAST);
    sel_y  = '0;
    sel_cf = 1'b0;
    if (op_sel == OP_XTR) begin
      sel_y = xtr_y;
    end else if (legal) begin
      sel_y  = trl_y;
      sel_cf = trl_cf;
    end
  end

  tbm_flags #(.W(W)) u_flg (
    .y(sel_y), .cf_in(sel_cf), .legal(legal), .f(fl_d)
  );

  logic [W-1:0] res_q;
  tbm_flags_t   fl_q;
  logic         ill_q;

  generate
    if (PIPE != 0) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_q <= '0;
          fl_q  <= '0;
          ill_q <= 1'b0;
        end else begin
          res_q <= sel_y;
          fl_q  <= fl_d;
          ill_q <= ~legal;
        end
      end
    end else begin : g_comb
      assign res_q = sel_y;
      assign fl_q  = fl_d;
      assign ill_q = ~legal;
    end
  endgenerate

  assign result     = res_q;
  assign result_zx  = {{W{1'b0}}, res_q};
  assign flag_zf    = fl_q.zf;
  assign flag_sf    = fl_q.sf;
  assign flag_pf    = fl_q.pf;
  assign flag_of    = fl_q.of;
  assign flag_cf    = fl_q.cf;
  assign flag_af    = fl_q.af;
  assign illegal_op = ill_q;
endmodule

// File: rtl/tbm_alu_chk.sv
module tbm_alu_chk #(
  parameter int W    = 32,
  parameter int CW   = 16,
  parameter int PIPE = 1
) (
  input logic           clk,
  input logic           rst,
  input logic [3:0]     op_sel,
  input logic [W-1:0]   src,
  input logic [CW-1:0]  ctrl,
  input logic [W-1:0]   result,
  input logic [2*W-1:0] result_zx,
  input logic           flag_zf,
  input logic           flag_sf,
  input logic           flag_pf,
  input logic           flag_of,
  input logic           flag_cf,
  input logic           flag_af,
  input logic           illegal_op
);
  generate
    if (PIPE != 0) begin : g_props
      // R2
      zext_chk: assert property (@(posedge clk) disable iff (rst)
        result_zx == {{W{1'b0}}, result});
      // R7
      no_of_af_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_of && !flag_af);
      // R6
      zf_chk: assert property (@(posedge clk) disable iff (rst)
        flag_zf |-> (result == '0));
      // R6
      sf_chk: assert property (@(posedge clk) disable iff (rst)
        !illegal_op |-> (flag_sf == result[W-1]));
      // R8
      inc_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 4'd1 && op_sel <= 4'd6) |=> (flag_cf == $past(&src)));
      // R9
      dec_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel >= 4'd7 && op_sel <= 4'd9) |=> (flag_cf == $past(src == '0)));
      // R10
      xtr_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel == 4'd0) |=> !flag_cf);
      // R11
      illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel > 4'd9) |=> (illegal_op && result == '0 && !flag_zf &&
                            !flag_sf && !flag_pf && !flag_cf));
      // R11
      legal_ok_chk: assert property (@(posedge clk) disable iff (rst)
        (op_sel <= 4'd9) |=> !illegal_op);
    end
  endgenerate
endmodule

bind tbm_alu tbm_alu_chk #(.W(W), .CW(CW), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .src(src), .ctrl(ctrl),
  .result(result), .result_zx(result_zx), .flag_zf(flag_zf),
  .flag_sf(flag_sf), .flag_pf(flag_pf), .flag_of(flag_of),
  .flag_cf(flag_cf), .flag_af(flag_af), .illegal_op(illegal_op)
);

// File: tb/tb_tbm_alu.sv
module tb_tbm_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [31:0] src = '0;
  logic [15:0] ctrl = '0;
  logic [31:0] result;
  logic [63:0] result_zx;
  logic flag_zf, flag_sf, flag_pf, flag_of, flag_cf, flag_af, illegal_op;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  tbm_alu dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .src(src), .ctrl(ctrl),
    .result(result), .result_zx(result_zx), .flag_zf(flag_zf),
    .flag_sf(flag_sf), .flag_pf(flag_pf), .flag_of(flag_of),
    .flag_cf(flag_cf), .flag_af(flag_af), .illegal_op(illegal_op)
  );

  typedef struct {
    logic [3:0]  op;
    logic [31:0] x;
    logic [15:0] c;
    logic [31:0] r;
    logic zf, sf, pf, cf, ill;
  } exp_t;

  exp_t q[$];

  function automatic exp_t model(logic [3:0] op, logic [31:0] x, logic [15:0] c);
    exp_t e;
    logic [31:0] i, d;
    int s, l;
    i = x + 32'd1;
    d = x - 32'd1;
    e.op = op; e.x = x; e.c = c;
    e.r = '0; e.cf = 1'b0; e.ill = 1'b0;
    s = int'(c[7:0]);
    l = int'(c[15:8]);
    case (op)
      4'd0: begin // R3
        if (s >= 32 || l == 0) e.r = '0;
        else begin
          e.r = x >> s;
          if (l < 32) e.r = e.r & 32'((64'd1 << l) - 64'd1);
        end
      end
      4'd1: e.r = i & x;   // R4
      4'd2: e.r = ~i | x;
      4'd3: e.r = i & ~x;
      4'd4: e.r = i ^ x;
      4'd5: e.r = i | x;
      4'd6: e.r = i | ~x;
      4'd7: e.r = d | x;   // R5
      4'd8: e.r = d | ~x;
      4'd9: e.r = d & ~x;
      default: e.ill = 1'b1;
    endcase
    if (op >= 4'd1 && op <= 4'd6) e.cf = (x == 32'hFFFF_FFFF); // R8
    if (op >= 4'd7 && op <= 4'd9) e.cf = (x == 32'h0);         // R9
    if (e.ill) begin
      e.zf = 1'b0; e.sf = 1'b0; e.pf = 1'b0;
    end else begin
      e.zf = (e.r == 0);
      e.sf = e.r[31];
      e.pf = ~^e.r[7:0];
    end
    return e;
  endfunction

  task automatic fail_line(string req, string what, logic [63:0] act, logic [63:0] exp,
                           logic [3:0] op, logic [31:0] x);
    n_bad++;
    $display("FAIL %s %s op=%0d src=%h actual=%h expected=%h", req, what, op, x, act, exp);
  endtask

  // driver
  task automatic apply(logic [3:0] op, logic [31:0] x, logic [15:0] c);
    @(negedge clk);
    op_sel = op; src = x; ctrl = c;
    q.push_back(model(op, x, c));
  endtask

  // monitor: output registered at posedge, compared just after it
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && q.size() > 0) begin
        exp_t e;
        string rq;
        e = q.pop_front();
        n_vec++;
        rq = (e.op == 0) ? "R3" : (e.op <= 6) ? "R4" : (e.op <= 9) ? "R5" : "R11";
        if (result !== e.r) fail_line(rq, "result", 64'(result), 64'(e.r), e.op, e.x);
        if (result_zx !== {32'h0, e.r}) fail_line("R2", "result_zx", result_zx, {32'h0, e.r}, e.op, e.x);
        if ({flag_zf, flag_sf, flag_pf} !== {e.zf, e.sf, e.pf})
          fail_line(e.ill ? "R11" : "R6", "zf/sf/pf", 64'({flag_zf, flag_sf, flag_pf}),
                    64'({e.zf, e.sf, e.pf}), e.op, e.x);
        if ({flag_of, flag_af} !== 2'b00) fail_line("R7", "of/af", 64'({flag_of, flag_af}), 64'd0, e.op, e.x);
        if (flag_cf !== e.cf) begin
          if (e.op == 0)      fail_line("R10", "cf", 64'(flag_cf), 64'(e.cf), e.op, e.x);
          else if (e.op <= 6) fail_line("R8", "cf", 64'(flag_cf), 64'(e.cf), e.op, e.x);
          else if (e.op <= 9) fail_line("R9", "cf", 64'(flag_cf), 64'(e.cf), e.op, e.x);
          else                fail_line("R11", "cf", 64'(flag_cf), 64'(e.cf), e.op, e.x);
        end
        if (illegal_op !== e.ill) fail_line("R11", "illegal_op", 64'(illegal_op), 64'(e.ill), e.op, e.x);
      end
    end
  end

  task automatic check_reset();
    n_vec++;
    if ({result, result_zx, flag_zf, flag_sf, flag_pf, flag_of, flag_cf, flag_af, illegal_op} !== '0) begin
      n_bad++;
      $display("FAIL R1 reset outputs actual=%h expected=0", {result, flag_zf, flag_sf, flag_pf,
               flag_of, flag_cf, flag_af, illegal_op});
    end
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  logic [31:0] pats [0:7];

  initial begin
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0000_0001;
    pats[3] = 32'h8000_0000; pats[4] = 32'hAAAA_AAAA; pats[5] = 32'h5555_5555;
    pats[6] = 32'h0000_0FF0; pats[7] = 32'h7FFF_FFFF;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check_reset();
    @(negedge clk) rst = 1'b0;

    // R4 R5 R8 R9 R11: every select over fixed patterns
    for (int op = 0; op < 16; op++)
      for (int p = 0; p < 8; p++)
        apply(4'(op), pats[p], 16'h0810);
    // single-bit operands
    for (int b = 0; b < 32; b++)
      for (int op = 1; op < 10; op++)
        apply(4'(op), 32'h1 << b, 16'h0);
    // R3: extract corners (start, length)
    for (int p = 0; p < 8; p++) begin
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'h0000); // len 0
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'h0804); // start 4 len 8
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'h081C); // runs off bit 31
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'h1020); // start 32
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'h01C8); // start 200
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'h2000); // len 32
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'hFF03); // len 255
      apply(4'd0, pats[p] ^ 32'hDEAD_BEEF, 16'h011F); // top bit only
    end
    // random operands and controls, all selects
    for (int k = 0; k < 600; k++)
      apply(4'($urandom_range(0, 15)), $urandom, 16'($urandom));
    drain();

    // R1: reset mid-run clears outputs
    @(negedge clk) begin rst = 1'b1; op_sel = 4'd2; src = 32'h1234_5678; end
    @(posedge clk);
    #1 check_reset();
    @(negedge clk) rst = 1'b0;
    apply(4'd6, 32'hFFFF_FFFF, 16'h0);
    apply(4'd9, 32'h0, 16'h0);
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule